// File: doc/BRIEF.md
# Comma-Aligned Word Deserializer with Twin Half-Rate Clocks

The block takes a serial bit stream that has already been retimed to a bit clock and rebuilds it into 10-bit words. It keeps a sliding window over the most recent ten bits. When word alignment is enabled, it watches that window on every bit for the positive-disparity comma. When a comma turns up off the current word boundary, or on a boundary of the wrong clock phase, the bit counter restarts. This moves the boundary without ever cutting an output clock level short.

Each word is presented with two registered clocks that run at half the word rate and are complementary. The word register changes on every level change, so words alternate between the rising edge of the primary clock and the rising edge of the secondary one. A comma word is always presented on a rising edge of the primary clock, together with a one-bit-cycle byte-sync pulse. With alignment disabled, the block is a free-running 1-to-10 deserializer: no realignment and no sync pulses.

Top module: `comma_deser`

## Requirements
- R1: The first bit received of a word becomes bit 0 (LSB) of `word_q`; bit 9 is the last bit received.
- R2: In steady state, a new word is loaded every 10 bit cycles. `hclk_p` toggles exactly when a word is loaded, and `hclk_n` is always the complement of `hclk_p`.
- R3: A comma is a window whose first seven received bits are 0,0,1,1,1,1,1, that is `word_q[6:0] == 7'b1111100`. The full positive K28.5 word appears as `word_q == 10'h17C`.
- R4: A comma word is loaded only together with a rising edge of `hclk_p`.
- R5: No high or low level of `hclk_p`/`hclk_n` lasts fewer than 10 bit cycles. Realignment only lengthens levels.
- R6: With a comma as the first word of every 4-word set, the comma of the second set is the first comma presented, whatever the starting bit offset.
- R7: `sync_q` is high for exactly the bit cycle in which a comma word is first presented, and only while `align_en` is high.
- R8: With `align_en` low, commas cause no realignment and no sync pulse, and every clock level lasts exactly 10 bit cycles.
- R9: While `rst_n` is low, `word_q` is 0, `hclk_p` is 0, `hclk_n` is 1 and `sync_q` is 0.
- R10: Once the first comma has been presented, every later word equals the transmitted word, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Retimed serial data, sampled on each rising `clk` edge |
| align_en | input | 1 | High enables comma search and realignment |
| word_q | output | 10 | Rebuilt word, bit 0 received first |
| hclk_p | output | 1 | Half-rate word clock; commas arrive on its rising edge |
| hclk_n | output | 1 | Complement of `hclk_p` |
| sync_q | output | 1 | One-bit-cycle strobe marking a presented comma |

## Verification
The hardest situations to reach are the three ways a first comma can land. It can be off the boundary while the primary clock is low, which needs a whole extra word of low stretch. It can be off the boundary while the clock is high. Or it can be exactly on a boundary but on the falling phase. Each of these must end aligned by the next set. The bench reaches each case by choosing the count of idle bits and filler words between reset release and the first comma. It then runs a scoreboard of the transmitted words against every presented word. At every clock level change it also measures the level's length in bit cycles.

// File: rtl/comma_deser.sv
module comma_deser #(
  parameter int WLEN = 10,
  parameter int MBITS = 7,
  parameter logic [MBITS-1:0] MARK = 7'b1111100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ser_in,
  input  logic            align_en,
  output logic [WLEN-1:0] word_q,
  output logic            hclk_p,
  output logic            hclk_n,
  output logic            sync_q
);
  localparam int CW = $clog2(WLEN);
  localparam logic [CW-1:0] LAST = CW'(WLEN - 1);

  logic [WLEN-1:0] shreg;
  logic [CW-1:0]   cnt;
  logic            skip;

  wire [WLEN-1:0] win     = {ser_in, shreg[WLEN-1:1]};
  wire            hit     = align_en && (win[MBITS-1:0] == MARK);
  wire            at_edge = (cnt == LAST);
  wire            take    = hit && at_edge && !hclk_p && !skip;
  wire            realign = hit && !take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      cnt    <= '0;
      skip   <= 1'b0;
      word_q <= '0;
      hclk_p <= 1'b0;
      hclk_n <= 1'b1;
      sync_q <= 1'b0;
    end else begin
      shreg  <= win;
      sync_q <= 1'b0;
      if (realign) begin
        cnt  <= '0;
        skip <= !hclk_p;
      end else if (at_edge) begin
        cnt <= '0;
        if (skip) begin
          skip <= 1'b0;
        end else begin
          word_q <= win;
          hclk_p <= !hclk_p;
          hclk_n <= hclk_p;
          sync_q <= take;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  logic       last_p;
  logic [7:0] plen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_p <= 1'b0;
      plen   <= 8'd0;
    end else if (hclk_p != last_p) begin
      last_p <= hclk_p;
      plen   <= 8'd1;
    end else if (plen != 8'hFF) begin
      plen <= plen + 1'b1;
    end
  end

  // R2
  clk_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hclk_n == !hclk_p);

  // R2
  word_on_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_q) |-> !$stable(hclk_p));

  // R4
  comma_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |-> ($rose(hclk_p) && word_q[MBITS-1:0] == MARK));

  // R7
  sync_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |-> $past(align_en));

  // R5
  min_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hclk_p != last_p) |-> (plen >= 8'(WLEN)));
endmodule

// File: tb/comma_deser_bench.sv
module comma_deser_bench;
  localparam int W = 10;
  localparam logic [9:0] KPOS = 10'h17C;

  logic clk = 1'b0, rst_n = 1'b0, ser_in = 1'b0, align_en = 1'b0;
  logic [9:0] word_q;
  logic hclk_p, hclk_n, sync_q;

  comma_deser u_comma_deser (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .align_en(align_en),
    .word_q(word_q), .hclk_p(hclk_p), .hclk_n(hclk_n), .sync_q(sync_q)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  logic [9:0] expq[$];
  int set_idx = -1, first_sync_set = -1, sync_seen = 0, plen = 0;
  bit mon_on = 0;
  logic last_p = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    ser_in = b;
  endtask

  task automatic send_word(input logic [9:0] w, input bit push);
    if (push) expq.push_back(w);
    for (int i = 0; i < W; i++) send_bit(w[i]);
  endtask

  function automatic logic [9:0] rnd_data();
    return 10'($urandom) & 10'h1EF;
  endfunction

  task automatic do_reset(input logic en);
    rst_n = 1'b0;
    ser_in = 1'b0;
    align_en = en;
    repeat (3) @(negedge clk);
    check(word_q == 10'd0, "R9 word_q in reset", word_q, 0);
    check(hclk_p == 1'b0 && hclk_n == 1'b1, "R9 clocks in reset", {hclk_p, hclk_n}, 2'b01);
    check(sync_q == 1'b0, "R9 sync_q in reset", sync_q, 0);
    expq.delete();
    mon_on = 0; last_p = 1'b0; plen = 0;
    set_idx = -1; first_sync_set = -1; sync_seen = 0;
    rst_n = 1'b1;
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      plen++;
      if (sync_q && hclk_p == last_p)
        check(0, "R7 sync without new word", sync_q, 0);
      if (hclk_p != last_p) begin
        check(plen - 1 >= W, "R5 clock level length", plen - 1, W);
        if (!align_en) check(plen - 1 == W, "R8 level length without alignment", plen - 1, W);
        check(hclk_n == ~hclk_p, "R2 complementary clocks", hclk_n, ~hclk_p);
        if (sync_q) begin
          sync_seen++;
          check(align_en, "R8 sync while alignment off", 1, 0);
          check(hclk_p == 1'b1, "R4 comma on rising primary clock", hclk_p, 1);
          check(word_q == KPOS, "R3 comma word value", word_q, KPOS);
          if (!mon_on) begin
            mon_on = 1;
            first_sync_set = set_idx;
          end
        end
        if (mon_on) begin
          if (expq.size() == 0) check(0, "R10 unexpected word", word_q, 0);
          else begin
            logic [9:0] e;
            e = expq.pop_front();
            check(word_q == e, "R10 word sequence (R1 LSB first)", word_q, e);
          end
        end
        last_p = hclk_p;
        plen = 1;
      end
    end
  end

  task automatic run_scn(input int offs, input int fillers);
    do_reset(1'b1);
    for (int i = 0; i < offs; i++) send_bit(1'b0);
    for (int i = 0; i < fillers; i++) send_word(rnd_data(), 0);
    for (int s = 0; s < 5; s++) begin
      set_idx = s;
      send_word(KPOS, s >= 1);
      for (int j = 0; j < 3; j++) send_word(rnd_data(), s >= 1);
    end
    send_word(rnd_data(), 1);
    repeat (3) @(negedge clk);
    #2;
    check(first_sync_set == 1, "R6 first comma presented in second set", first_sync_set, 1);
    check(sync_seen == 4, "R7 sync pulse count", sync_seen, 4);
    check(expq.size() == 0, "R10 all words presented", expq.size(), 0);
  endtask

  initial begin
    run_scn(3, 1);
    run_scn(6, 0);
    run_scn(9, 2);
    do_reset(1'b0);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    for (int s = 0; s < 5; s++) begin
      send_word(KPOS, 0);
      for (int j = 0; j < 3; j++) send_word(rnd_data(), 0);
    end
    repeat (3) @(negedge clk);
    #2;
    check(sync_seen == 0, "R8 no sync with alignment off", sync_seen, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule